// File: doc/BRIEF.md
# Parallel Port with Serial Output Takeover

This block is an 8-bit bidirectional pin port for a microcontroller-style subsystem. Software reaches it through a small register interface: a 2-bit address, a write strobe, write data and a combinational read-data bus. Three per-bit registers control the pins. The output latch holds the value to drive. The direction register makes a pin an output when its bit is 1. The pulldown-inhibit register switches off the weak pulldown when its bit is 1. Each pin produces three signals for its pad (drive value, drive enable and pulldown enable) and takes one raw input level back from it.

One pin, the shared pin (bit 5 by default), can be taken over by a serial peripheral. While the peripheral's enable input is high, that pin is driven from the peripheral's data output and its pulldown is held off. Software can still read and write all three registers during this time, and those accesses do not disturb the serial stream. When the enable falls, the stored register bits take control of the pin again in the same cycle, with no clock edge needed.

Pad levels pass through a two-stage synchronizer before they reach the read path. Reading the latch address returns, for each bit, the stored latch value if the bit is an output, and the synchronized pin level if it is an input.

Top module: `pio_port`

## Requirements
- R1: After reset, all three registers read 0. Every pin has drive enable low and pulldown enable high.
- R2: A write with the strobe high updates the selected register on that clock edge. The addresses are 0 for the latch, 1 for direction and 2 for pulldown inhibit. A write to address 3 changes nothing, and a read of address 3 returns 0.
- R3: A pin whose direction bit is 1 (and that is not under takeover) has drive enable high, drives its latch bit and has pulldown enable low.
- R4: A pin whose direction bit is 0 (and that is not under takeover) has drive enable low. Its pulldown enable is high exactly when its inhibit bit is 0.
- R5: A latch read returns the latch bit for output pins and the pad level for input pins. The pad level is delayed by two clock edges through the synchronizer.
- R6: While the serial enable is high, the shared pin has drive enable high, drives the serial data input and has pulldown enable low, whatever the register contents.
- R7: While the serial enable is high, writes to the shared bit of any register are stored and read back, but they do not change the shared pin's outputs.
- R8: When the serial enable goes low, the shared pin's three outputs follow its stored latch, direction and inhibit bits in the same cycle, without waiting for a clock edge.
- R9: While the serial enable is high and the shared bit's direction is 0, a latch read returns the synchronized pad level on bit 5.
- R10: The serial enable and serial data have no effect on any pin other than the shared one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 latch, 1 direction, 2 pulldown inhibit |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the register at reg_addr |
| ser_en | input | 1 | Serial peripheral takes over the shared pin when high |
| ser_dout | input | 1 | Serial peripheral data output |
| pad_in | input | 8 | Raw pad input levels (asynchronous) |
| pad_out | output | 8 | Value driven onto each pad |
| pad_oe | output | 8 | Drive enable for each pad |
| pad_pd | output | 8 | Pulldown enable for each pad |

## Verification
The assertions assume that reg_addr, reg_wr, reg_wdata, ser_en and ser_dout are synchronous to clk and free of X once reset is released. They also assume that the takeover enable is the only thing that can change the shared pin outside a register write. Only pad_in may change at any time. The stimulus changes every synchronous input just after a falling edge. It moves the serial enable only between writes, so the hold-when-idle and takeover properties see clean, settled inputs at each rising edge.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int unsigned PIO_ADDR_W = 2;

    typedef enum logic [PIO_ADDR_W-1:0] {
        SEL_LATCH = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_PDINH = 2'd2,
        SEL_NONE  = 2'd3
    } pio_sel_e;
endpackage

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  pio_sel_e         wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pdinh_q
);
    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] pdinh;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_LATCH: bank_d.latch = wr_data;
                SEL_DIR:   bank_d.dir   = wr_data;
                SEL_PDINH: bank_d.pdinh = wr_data;
                default:   bank_d       = bank_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign latch_q = bank_q.latch;
    assign dir_q   = bank_q.dir;
    assign pdinh_q = bank_q.pdinh;
endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d.stage[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d.stage[s] = chain_q.stage[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q.stage[STAGES-1];
endmodule

// File: rtl/pio_pinmux.sv
module pio_pinmux #(
    parameter int unsigned WIDTH      = 8,
    parameter int unsigned SHARED_BIT = 5
) (
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] pdinh,
    input  logic             ovr_en,
    input  logic             ovr_data,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_pd
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (i == SHARED_BIT) begin : g_shared
            always_comb begin
                if (ovr_en) begin
                    pin_out[i] = ovr_data;
                    pin_oe[i]  = 1'b1;
                    pin_pd[i]  = 1'b0;
                end else begin
                    pin_out[i] = latch[i];
                    pin_oe[i]  = dir[i];
                    pin_pd[i]  = ~dir[i] & ~pdinh[i];
                end
            end
        end else begin : g_plain
            always_comb begin
                pin_out[i] = latch[i];
                pin_oe[i]  = dir[i];
                pin_pd[i]  = ~dir[i] & ~pdinh[i];
            end
        end
    end
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SHARED_BIT  = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIO_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr,
    input  logic [WIDTH-1:0]      reg_wdata,
    output logic [WIDTH-1:0]      reg_rdata,
    input  logic                  ser_en,
    input  logic                  ser_dout,
    input  logic [WIDTH-1:0]      pad_in,
    output logic [WIDTH-1:0]      pad_out,
    output logic [WIDTH-1:0]      pad_oe,
    output logic [WIDTH-1:0]      pad_pd
);
    pio_sel_e         sel;
    logic [WIDTH-1:0] latch_q, dir_q, pdinh_q, pin_sync;

    assign sel = pio_sel_e'(reg_addr);

    pio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (sel),
        .wr_data (reg_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .pdinh_q (pdinh_q)
    );

    pio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    pio_pinmux #(.WIDTH(WIDTH), .SHARED_BIT(SHARED_BIT)) u_mux (
        .latch    (latch_q),
        .dir      (dir_q),
        .pdinh    (pdinh_q),
        .ovr_en   (ser_en),
        .ovr_data (ser_dout),
        .pin_out  (pad_out),
        .pin_oe   (pad_oe),
        .pin_pd   (pad_pd)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_LATCH: begin
                for (int i = 0; i < WIDTH; i++) begin
                    reg_rdata[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
                end
            end
            SEL_DIR:   reg_rdata = dir_q;
            SEL_PDINH: reg_rdata = pdinh_q;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
    parameter int unsigned WIDTH      = 8,
    parameter int unsigned SHARED_BIT = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_addr,
    input logic             reg_wr,
    input logic [WIDTH-1:0] reg_rdata,
    input logic             ser_en,
    input logic             ser_dout,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_pd
);
    localparam logic [WIDTH-1:0] SH_MASK = {{(WIDTH-1){1'b0}}, 1'b1} << SHARED_BIT;

    p_reset_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_oe == '0) && (pad_pd == '1));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(pad_oe & ~SH_MASK) && $stable(pad_pd & ~SH_MASK));

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd3) |-> (reg_rdata == '0));

    p_dir_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd1) |-> (((reg_rdata ^ pad_oe) & ~SH_MASK) == '0));

    p_drive_nopull_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pd) == '0);

    p_latch_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (((reg_rdata ^ pad_out) & pad_oe & ~SH_MASK) == '0));

    p_takeover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en |-> pad_oe[SHARED_BIT] && !pad_pd[SHARED_BIT]
                   && (pad_out[SHARED_BIT] == ser_dout));

    p_takeover_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && $past(ser_en) && $stable(ser_dout)) |->
            $stable(pad_out[SHARED_BIT]) && $stable(pad_oe[SHARED_BIT]));
endmodule

bind pio_port pio_port_chk #(.WIDTH(WIDTH), .SHARED_BIT(SHARED_BIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .ser_en    (ser_en),
    .ser_dout  (ser_dout),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pd    (pad_pd)
);

// File: tb/pio_port_tb.sv
`timescale 1ns/100ps
module pio_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ser_en = 1'b0;
    logic       ser_dout = 1'b0;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe, pad_pd;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // behavioural reference state
    bit [7:0] m_lat = 0, m_dir = 0, m_inh = 0;
    bit [7:0] m_s1 = 0, m_s2 = 0;

    always #2 clk = ~clk;

    pio_port dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_en(ser_en),
        .ser_dout(ser_dout), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pd(pad_pd)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lat = 0; m_dir = 0; m_inh = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            if (reg_wr) begin
                if (reg_addr == 2'd0) m_lat = reg_wdata;
                else if (reg_addr == 2'd1) m_dir = reg_wdata;
                else if (reg_addr == 2'd2) m_inh = reg_wdata;
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    function automatic bit [7:0] exp_out();
        bit [7:0] r = m_lat;
        if (ser_en) r[5] = ser_dout;
        return r;
    endfunction
    function automatic bit [7:0] exp_oe();
        bit [7:0] r = m_dir;
        if (ser_en) r[5] = 1'b1;
        return r;
    endfunction
    function automatic bit [7:0] exp_pd();
        bit [7:0] r = ~m_dir & ~m_inh;
        if (ser_en) r[5] = 1'b0;
        return r;
    endfunction
    function automatic bit [7:0] exp_rd();
        if (reg_addr == 2'd0) return (m_lat & m_dir) | (m_s2 & ~m_dir);
        if (reg_addr == 2'd1) return m_dir;
        if (reg_addr == 2'd2) return m_inh;
        return 8'h00;
    endfunction

    // per-cycle comparison against the reference (R3 R4 R5 R6 R10)
    always @(negedge clk) begin
        if (!finished) begin
            chk("R3/R6 cycle pad_out", pad_out, exp_out());
            chk("R4/R10 cycle pad_oe", pad_oe, exp_oe());
            chk("R4/R6 cycle pad_pd", pad_pd, exp_pd());
            chk("R5 cycle rdata", reg_rdata, exp_rd());
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        idle(2);
        // R1 reset state
        chk("R1 oe in reset", pad_oe, 8'h00);
        chk("R1 pd in reset", pad_pd, 8'hFF);
        rst_n = 1'b1;
        idle(1);
        rd(2'd0, 8'h00, "R1 latch read");
        rd(2'd1, 8'h00, "R1 dir read");
        rd(2'd2, 8'h00, "R1 inhibit read");

        // R3 outputs, R4 pulldowns
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'hA5);
        chk("R3 oe", pad_oe, 8'h0F);
        chk("R3 out low nibble", pad_out & 8'h0F, 8'h05);
        chk("R4 pd no inhibit", pad_pd, 8'hF0);
        wr(2'd2, 8'h10);
        chk("R4 pd with inhibit", pad_pd, 8'hE0);

        // R5 readback and synchronizer latency
        pad_in = 8'h3C;
        idle(3);
        rd(2'd0, 8'h35, "R5 mixed readback");
        @(negedge clk); #1;
        pad_in = 8'hF0;
        idle(1);
        rd(2'd0, 8'h35, "R5 one edge old value");
        idle(1);
        rd(2'd0, 8'hF5, "R5 two edges new value");

        // R2 unmapped address
        wr(2'd3, 8'hFF);
        rd(2'd3, 8'h00, "R2 unmapped read");
        rd(2'd1, 8'h0F, "R2 dir unchanged");
        rd(2'd2, 8'h10, "R2 inhibit unchanged");

        // R6 takeover, R10 other pins
        @(negedge clk); #1;
        ser_en = 1'b1; ser_dout = 1'b1;
        #0.5;
        chk("R6 shared out", {7'd0, pad_out[5]}, 8'h01);
        chk("R6 pd", pad_pd, 8'hC0);
        chk("R10 oe others", pad_oe, 8'h2F);
        @(negedge clk); #1;
        ser_dout = 1'b0;
        #0.5;
        chk("R6 follows serial data", {7'd0, pad_out[5]}, 8'h00);
        ser_dout = 1'b1;

        // R7 registers usable during takeover
        wr(2'd0, 8'h00);
        chk("R7 shared out kept", {7'd0, pad_out[5]}, 8'h01);
        wr(2'd2, 8'h30);
        chk("R7 pd kept", pad_pd, 8'hC0);
        rd(2'd2, 8'h30, "R7 inhibit readback");
        rd(2'd1, 8'h0F, "R7 dir readback");

        // R9 pin level readback while owned
        rd(2'd0, 8'hF0, "R9 pin high");
        @(negedge clk); #1;
        pad_in = 8'hD0;
        idle(3);
        rd(2'd0, 8'hD0, "R9 pin low");

        // R8 immediate release
        wr(2'd1, 8'h2F);
        chk("R7 oe during takeover", pad_oe, 8'h2F);
        @(negedge clk); #1;
        ser_en = 1'b0;
        #0.5;
        chk("R8 out released", {7'd0, pad_out[5]}, 8'h00);
        chk("R8 oe released", pad_oe, 8'h2F);
        chk("R8 pd released", pad_pd, 8'hC0);
        wr(2'd1, 8'h0F);
        chk("R4 inhibited input", pad_pd, 8'hC0);
        wr(2'd2, 8'h10);
        chk("R4 shared pulldown on", pad_pd, 8'hE0);
        idle(2);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule